// File: doc/BRIEF.md
# ECC Write-Path Check-Bit Corruptor

This block sits between the ECC encoder and the memory on the write path. It passes each encoded word (data plus check field) through with one register stage. On command it flips chosen check bits of exactly one later write. The read path and the error logging can then be exercised with a known fault. The flip is an XOR of an 8-bit pattern chosen by software into the check field. The same mechanism therefore makes either a single-bit fault or a double-bit fault. A single check bit i is hit with pattern 1<<i. A single data bit is hit with the syndrome of that data bit's matrix column. A double fault uses pattern 0x03.

Software programs a 32-bit control register. Bits [23:16] hold the XOR pattern. Bit 24 is a writeback flag, which is set for correctable injections and clear for uncorrectable ones. Bit 28 is a trigger that clears itself. The trigger becomes effective only after the write-queue busy input has been seen low. A trigger written while the queue is busy waits until the queue drains. The corrupted word leaves the block with a marker and a copy of the writeback flag. The downstream logic uses the flag to decide whether the corrected data is written back.

Top module: `wpath_ecc_injector`

## Requirements
- R1: After synchronous reset, the control read-back is 0, `out_valid` is low, `out_inj` is low and `out_wb` is low.
- R2: A control write stores the pattern from write bits [23:16] and the writeback flag from bit 24. The read-back returns them at the same positions from the cycle after the write, and every other read-back bit except bit 28 reads 0.
- R3: A control write with bit 28 set makes read-back bit 28 read 1. That bit reads 0 again in the cycle in which the corrupted word is presented at the outputs.
- R4: With no live trigger, every input word appears unchanged on `out_word` one cycle later, with `out_valid` high and `out_inj` low.
- R5: While `wq_busy` is high, a pending trigger corrupts nothing, and the words that pass meanwhile come out unchanged.
- R6: The trigger becomes live after a clock edge at which `wq_busy` was sampled low. The first input word after that comes out with bits [71:64] XORed with the pattern and bits [63:0] unchanged. The next word is clean.
- R7: `out_inj` is high only with the corrupted word. `out_wb` is high with it only when the stored writeback flag is 1.
- R8: A control write with bit 28 clear cancels a pending trigger. Later words then pass clean and read-back bit 28 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control write data: [23:16] pattern, [24] writeback, [28] trigger |
| cfg_rdata | output | 32 | Control read-back: pattern, writeback and trigger pending |
| wq_busy | input | 1 | Write queue has a write queued or in flight |
| in_valid | input | 1 | Encoded write word valid |
| in_word | input | 72 | Encoded word: [63:0] data, [71:64] check bits |
| out_valid | output | 1 | Output word valid |
| out_word | output | 72 | Possibly corrupted word |
| out_inj | output | 1 | This output word carries the injected fault |
| out_wb | output | 1 | Writeback requested for the injected fault |

## Verification
Every word result is due one clock after its input word was sampled. A control write shows on the read-back one clock after its strobe. A trigger turns live one clock after busy is sampled low, so only a word sampled at a later edge can carry the fault. A reference model in the bench runs at each rising edge on the same sampled inputs. It queues the expected word, marker and writeback flag, and a monitor compares them at the following falling edge. The read-back checks are taken at a falling edge after the edge that consumed the write or the corrupted word.

// File: rtl/wpi_pkg.sv
package wpi_pkg;
    localparam int CHK_W    = 8;
    localparam int REG_W    = 32;
    localparam int PAT_LSB  = 16;
    localparam int WB_BIT   = 24;
    localparam int TRIG_BIT = 28;

    typedef enum logic [1:0] {
        INJ_IDLE  = 2'd0,
        INJ_ARMED = 2'd1,
        INJ_LIVE  = 2'd2
    } inj_state_e;

    typedef struct packed {
        logic [CHK_W-1:0] pattern;
        logic             wb;
    } inj_cfg_t;

    function automatic inj_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        inj_cfg_t c;
        c.pattern = w[PAT_LSB +: CHK_W];
        c.wb      = w[WB_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input inj_cfg_t c, input logic pend);
        logic [REG_W-1:0] w;
        w = '0;
        w[PAT_LSB +: CHK_W] = c.pattern;
        w[WB_BIT]           = c.wb;
        w[TRIG_BIT]         = pend;
        return w;
    endfunction
endpackage

// File: rtl/wpi_ctrl.sv
module wpi_ctrl
    import wpi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             wq_busy,
    input  logic             fire,
    output logic             live,
    output inj_cfg_t         cfg
);
    inj_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= INJ_IDLE;
            cfg   <= '0;
        end else begin
            if (fire) begin
                state <= INJ_IDLE;
            end else if (state == INJ_ARMED && !wq_busy) begin
                state <= INJ_LIVE;
            end
            if (cfg_wr) begin
                cfg   <= unpack_cfg(cfg_wdata);
                state <= cfg_wdata[TRIG_BIT] ? INJ_ARMED : INJ_IDLE;
            end
        end
    end

    assign live      = (state == INJ_LIVE);
    assign cfg_rdata = pack_cfg(cfg, state != INJ_IDLE);

    AST_LIVE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(live) |-> !$past(wq_busy)) else $error("live while busy"); // R5

    AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (fire && !cfg_wr) |=> !cfg_rdata[TRIG_BIT]) else $error("trigger stuck"); // R3
endmodule

// File: rtl/wpi_corrupt.sv
module wpi_corrupt
    import wpi_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DATA_W+CHK_W-1:0] in_word,
    input  logic                    live,
    input  inj_cfg_t                cfg,
    output logic                    fire,
    output logic                    out_valid,
    output logic [DATA_W+CHK_W-1:0] out_word,
    output logic                    out_inj,
    output logic                    out_wb
);
    localparam int WORD_W = DATA_W + CHK_W;

    logic [WORD_W-1:0] flip;

    assign fire = live && in_valid;

    assign flip[DATA_W-1:0] = '0;
    for (genvar i = 0; i < CHK_W; i++) begin : g_chk
        assign flip[DATA_W+i] = fire && cfg.pattern[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_inj   <= 1'b0;
            out_wb    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_inj   <= fire;
            out_wb    <= fire && cfg.wb;
            if (in_valid) begin
                out_word <= in_word ^ flip;
            end
        end
    end

    AST_DATA_KEPT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_word[DATA_W-1:0] == $past(in_word[DATA_W-1:0])) else $error("data bits altered"); // R6

    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_inj) |-> out_word == $past(in_word)) else $error("clean word altered"); // R4

    AST_WB_QUAL: assert property (@(posedge clk) disable iff (rst)
        out_wb |-> out_inj) else $error("writeback without fault"); // R7

    AST_INJ_VALID: assert property (@(posedge clk) disable iff (rst)
        out_inj |-> out_valid) else $error("fault marker without word"); // R7
endmodule

// File: rtl/wpath_ecc_injector.sv
module wpath_ecc_injector
    import wpi_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [REG_W-1:0]        cfg_wdata,
    output logic [REG_W-1:0]        cfg_rdata,
    input  logic                    wq_busy,
    input  logic                    in_valid,
    input  logic [DATA_W+CHK_W-1:0] in_word,
    output logic                    out_valid,
    output logic [DATA_W+CHK_W-1:0] out_word,
    output logic                    out_inj,
    output logic                    out_wb
);
    logic     fire;
    logic     live;
    inj_cfg_t cfg;

    wpi_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .wq_busy   (wq_busy),
        .fire      (fire),
        .live      (live),
        .cfg       (cfg)
    );

    wpi_corrupt #(.DATA_W(DATA_W)) u_corrupt (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .live      (live),
        .cfg       (cfg),
        .fire      (fire),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_inj   (out_inj),
        .out_wb    (out_wb)
    );

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        out_inj |-> !(out_inj && $past(out_inj) && !$past(cfg_wr, 2))) else $error("two faults from one trigger"); // R6
endmodule

// File: tb/wpath_ecc_injector_tb_top.sv
module wpath_ecc_injector_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        wq_busy = 1'b0;
    logic        in_valid = 1'b0;
    logic [71:0] in_word = '0;
    logic        out_valid;
    logic [71:0] out_word;
    logic        out_inj;
    logic        out_wb;

    always #10 clk = ~clk;

    wpath_ecc_injector dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wq_busy(wq_busy), .in_valid(in_valid),
        .in_word(in_word), .out_valid(out_valid), .out_word(out_word),
        .out_inj(out_inj), .out_wb(out_wb)
    );

    typedef struct {
        logic [71:0] word;
        logic        inj;
        logic        wb;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    int       m_state = 0;
    bit [7:0] m_pat = 0;
    bit       m_wb = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_pat = 0; m_wb = 0;
        end else begin
            bit   f;
            exp_t e;
            f = (m_state == 2) && in_valid;
            if (in_valid) begin
                e.word = in_word;
                if (f) e.word[71:64] = in_word[71:64] ^ m_pat;
                e.inj = f;
                e.wb  = f && m_wb;
                e.req = f ? "R6/R7" : (m_state == 1 ? "R5" : "R4");
                exp_q.push_back(e);
            end
            if (f) m_state = 0;
            else if (m_state == 1 && !wq_busy) m_state = 2;
            if (cfg_wr) begin
                m_pat   = cfg_wdata[23:16];
                m_wb    = cfg_wdata[24];
                m_state = cfg_wdata[28] ? 1 : 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R4: unexpected word %h, expected none", out_word);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (out_word !== e.word || out_inj !== e.inj || out_wb !== e.wb) begin
                    n_bad++;
                    $display("FAIL %s: word %h inj %b wb %b, expected %h %b %b",
                             e.req, out_word, out_inj, out_wb, e.word, e.inj, e.wb);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic send(input logic [71:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_word = w;
        @(negedge clk);
        in_valid = 1'b0; in_word = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cw(input logic [7:0] p, input logic wb, input logic t);
        return {3'b0, t, 3'b0, wb, p, 16'h0};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", cfg_rdata, 32'h0);
        check("R1", {29'h0, out_valid, out_inj, out_wb}, 32'h0);

        for (int i = 0; i < 4; i++) send({8'(i * 37), 64'hA5A5_0000_1234_0000 + 64'(i)});

        cfg_write(cw(8'h03, 1'b0, 1'b1));
        check("R3", cfg_rdata, cw(8'h03, 1'b0, 1'b1));
        idle(1);
        @(negedge clk);
        in_valid = 1'b1; in_word = {8'h5C, 64'hDEAD_BEEF_0123_4567};
        @(negedge clk);
        in_valid = 1'b0;
        check("R3", cfg_rdata[28], 32'h0);
        send({8'h11, 64'h0F0F_0F0F_0F0F_0F0F});

        wq_busy = 1'b1;
        cfg_write(cw(8'h80, 1'b1, 1'b1));
        check("R2", cfg_rdata & 32'h01FF_0000, 32'h0180_0000);
        check("R2", cfg_rdata & 32'hEE00_FFFF, 32'h0);
        for (int i = 0; i < 3; i++) send({8'hF0, 64'(i) * 64'h1111});
        idle(2);
        check("R5", cfg_rdata[28], 32'h1);
        wq_busy = 1'b0;
        idle(2);
        send({8'h00, 64'hCAFE_F00D_0000_0001});
        send({8'h00, 64'hCAFE_F00D_0000_0002});

        wq_busy = 1'b1;
        cfg_write(cw(8'hF4, 1'b1, 1'b1));
        cfg_write(cw(8'hF4, 1'b1, 1'b0));
        check("R8", cfg_rdata[28], 32'h0);
        wq_busy = 1'b0;
        idle(2);
        send({8'h3C, 64'h1357_9BDF_2468_ACE0});
        check("R8", cfg_rdata, cw(8'hF4, 1'b1, 1'b0));

        cfg_write(cw(8'hF4, 1'b1, 1'b1));
        idle(1);
        @(negedge clk);
        in_valid = 1'b1; in_word = {8'hAA, 64'h1};
        @(negedge clk);
        in_word = {8'hBB, 64'h2};
        @(negedge clk);
        in_word = {8'hCC, 64'h3};
        @(negedge clk);
        in_valid = 1'b0;
        check("R3", cfg_rdata[28], 32'h0);
        idle(3);
        check("R4", exp_q.size(), 32'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule